// File: doc/BRIEF.md
# ATA Channel Soft-Reset Sequencer

This block runs the software-reset handshake on one ATA channel. It reaches the device through a small register bus. The bus has one read strobe, one write strobe, a 4-bit address, write data and read data. The data returned for a read is taken in the same cycle as the strobe.

The address encoding is fixed. Bit 3 selects the control block and bits 2:0 give the offset within the block. The status register is therefore address 0x7 (command block, offset 7). The device-control register is address 0xA (control block, offset 2).

A one-cycle `start` pulse begins the sequence, in this order:
1. Let a short settling delay pass.
2. Poll status until the busy flag (bit 7) reads clear.
3. Write the reset-assert value.
4. Look for the busy flag to rise within a short presence window.
5. Write the reset-release value.
6. Let the settling delay pass again.
7. Poll until busy clears.

All delays and time-outs are counted in pulses of the free-running `tick_ms` input. At the end the block raises `done` for one cycle. `err_code` is updated in that same cycle and then held: 0 means success, 1 means busy before reset, 2 means no device answered, 3 means busy after release.

Top module: `ata_srst_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle: `busy`=0, `done`=0, `err_code`=0, no read or write strobe, and address and write data are 0.
- R2: A `start` pulse seen in idle sets `busy` on the next cycle. No bus access happens until DLY_TICKS tick pulses have been counted.
- R3: During the first poll phase the block reads address 0x7 on every cycle. The first cycle that returns bit 7 clear is followed by a single write of 0x0E to address 0xA. The value 0x0E has bit 3 set, reset (bit 2) set and interrupt disable (bit 1) set. A read and a write never occur in the same cycle.
- R4: After the 0x0E write, the block reads status on every cycle. The first read with bit 7 set is followed by a single write of 0x0A to address 0xA, which releases reset and keeps interrupts disabled.
- R5: After the 0x0A write, the block waits DLY_TICKS ticks with no bus access and then polls status. The first read with bit 7 clear is followed by `done` with `err_code`=0.
- R6: If bit 7 is still set after TMO_TICKS ticks of the first poll phase, the sequence ends with `err_code`=1 and no reset is written.
- R7: If bit 7 is not seen within WIN_TICKS ticks after the reset write, the sequence ends with `err_code`=2.
- R8: If bit 7 is still set after TMO_TICKS ticks of the final poll phase, the sequence ends with `err_code`=3.
- R9: `done` lasts exactly one cycle and `busy` drops in the next cycle. A `start` pulse while `busy`=1 is ignored.
- R10: If a read returns bit 7 in the wanted state in the same cycle that its time-out is reached, the read result wins.
- R11: `err_code` changes only in the cycle in which `done` is high, and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per delay tick |
| start | input | 1 | Start request pulse |
| bus_addr | output | 4 | Register address (bit 3 = control block) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the strobe cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result of the last sequence |

## Verification
Two events can land in the same cycle: a status read that returns the awaited busy state, and the tick that makes its time-out expire. The bench sweeps how long the device stays busy before reset across the time-out boundary, one run per length, so that some runs clear exactly as the limit is reached. A behavioural model, compared against the design on every clock, judges each run. In every such case the outcome has to be a reset write rather than error 1. A second overlap, a fresh `start` arriving while a sequence is running, is provoked mid-run, and the bench checks that exactly one completion follows.

// File: rtl/ata_srst_pkg.sv
package ata_srst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE_PRE,
    ST_WAIT_IDLE,
    ST_PUT_RST,
    ST_SEEK_BSY,
    ST_DROP_RST,
    ST_SETTLE_POST,
    ST_WAIT_READY,
    ST_FINISH
  } seq_st_t;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_BUSY_PRE  = 2'd1,
    ERR_NO_DEV    = 2'd2,
    ERR_BUSY_POST = 2'd3
  } seq_err_t;

  localparam int unsigned BUS_AW   = 4;
  localparam int unsigned BSY_BIT  = 7;
  // status: command block offset 7; device control: control block (bit 3) offset 2
  localparam logic [BUS_AW-1:0] STS_ADDR  = 4'h7;
  localparam logic [BUS_AW-1:0] DCTL_ADDR = 4'hA;
  localparam logic [7:0] DCTL_SET = 8'h0E;
  localparam logic [7:0] DCTL_REL = 8'h0A;

endpackage

// File: rtl/ata_tick_cnt.sv
module ata_tick_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign hit = (cnt_q >= limit);

  always_comb begin
    cnt_en = clr | (tick & ~hit);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ata_srst_fsm.sv
module ata_srst_fsm
  import ata_srst_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DLY_TICKS = 2,
  parameter int unsigned WIN_TICKS = 2,
  parameter int unsigned TMO_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sts_bsy,
  input  logic             hit,
  output logic             clr,
  output logic [CNT_W-1:0] limit,
  output seq_st_t          st,
  output seq_err_t         err
);

  seq_st_t  st_q, st_d;
  seq_err_t err_q, err_d;
  logic     err_en;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    unique case (st_q)
      ST_IDLE:        if (start) st_d = ST_SETTLE_PRE;
      ST_SETTLE_PRE:  if (hit) st_d = ST_WAIT_IDLE;
      ST_WAIT_IDLE:
        if (!sts_bsy) st_d = ST_PUT_RST;
        else if (hit) begin st_d = ST_FINISH; err_d = ERR_BUSY_PRE; end
      ST_PUT_RST:     st_d = ST_SEEK_BSY;
      ST_SEEK_BSY:
        if (sts_bsy) st_d = ST_DROP_RST;
        else if (hit) begin st_d = ST_FINISH; err_d = ERR_NO_DEV; end
      ST_DROP_RST:    st_d = ST_SETTLE_POST;
      ST_SETTLE_POST: if (hit) st_d = ST_WAIT_READY;
      ST_WAIT_READY:
        if (!sts_bsy) begin st_d = ST_FINISH; err_d = ERR_NONE; end
        else if (hit) begin st_d = ST_FINISH; err_d = ERR_BUSY_POST; end
      ST_FINISH:      st_d = ST_IDLE;
      default:        st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_en = (st_d == ST_FINISH) && (st_q != ST_FINISH);
    clr    = (st_d != st_q);
    unique case (st_q)
      ST_SETTLE_PRE, ST_SETTLE_POST: limit = CNT_W'(DLY_TICKS);
      ST_SEEK_BSY:                   limit = CNT_W'(WIN_TICKS);
      default:                       limit = CNT_W'(TMO_TICKS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= ERR_NONE;
    end else begin
      st_q <= st_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign st  = st_q;
  assign err = err_q;

  // R6: a busy-before-reset error is only reachable from the first poll phase
  a_r6_busy_pre_src: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINISH && err_q == ERR_BUSY_PRE && $past(err_q) != ERR_BUSY_PRE)
      |-> $past(st_q) == ST_WAIT_IDLE);

  // R2: the settle phase only follows idle or continues itself
  a_r2_settle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE_PRE) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_SETTLE_PRE));

endmodule

// File: rtl/ata_srst_seq.sv
module ata_srst_seq
  import ata_srst_pkg::*;
#(
  parameter int unsigned DLY_TICKS = 2,
  parameter int unsigned WIN_TICKS = 2,
  parameter int unsigned TMO_TICKS = 32000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              start,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);

  localparam int unsigned CNT_W = $clog2(TMO_TICKS + 1);

  logic             rst_s1, rst_sn;
  logic             clr, hit;
  logic [CNT_W-1:0] limit;
  seq_st_t          st;
  seq_err_t         err;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  ata_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (clr),
    .tick  (tick_ms),
    .limit (limit),
    .hit   (hit)
  );

  ata_srst_fsm #(
    .CNT_W     (CNT_W),
    .DLY_TICKS (DLY_TICKS),
    .WIN_TICKS (WIN_TICKS),
    .TMO_TICKS (TMO_TICKS)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start   (start),
    .sts_bsy (bus_rdata[BSY_BIT]),
    .hit     (hit),
    .clr     (clr),
    .limit   (limit),
    .st      (st),
    .err     (err)
  );

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st)
      ST_WAIT_IDLE, ST_SEEK_BSY, ST_WAIT_READY: begin
        bus_rd   = 1'b1;
        bus_addr = STS_ADDR;
      end
      ST_PUT_RST: begin
        bus_wr    = 1'b1;
        bus_addr  = DCTL_ADDR;
        bus_wdata = DCTL_SET;
      end
      ST_DROP_RST: begin
        bus_wr    = 1'b1;
        bus_addr  = DCTL_ADDR;
        bus_wdata = DCTL_REL;
      end
      default: ;
    endcase
    busy     = (st != ST_IDLE);
    done     = (st == ST_FINISH);
    err_code = err;
  end

  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_rd && bus_wr));

  a_r3_rd_addr: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_rd |-> bus_addr == STS_ADDR);

  a_r4_set_then_poll: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && bus_wdata == DCTL_SET) |=> bus_rd);

  a_r5_rel_then_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && bus_wdata == DCTL_REL) |=> (!bus_rd && !bus_wr && busy));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> (!done && !busy));

  a_r11_err_on_done: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_code != $past(err_code)) |-> done);

endmodule

// File: tb/ata_srst_seq_tb.sv
module ata_srst_seq_tb_top;

  localparam int DLY = 2;
  localparam int WIN = 2;
  localparam int TMO = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       start = 1'b0;
  logic [3:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy, done;
  logic [1:0] err_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit run_cmp = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  ata_srst_seq #(.DLY_TICKS(DLY), .WIN_TICKS(WIN), .TMO_TICKS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start(start),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err_code(err_code)
  );

  // tick every fifth cycle
  int tc = 0;
  always @(negedge clk) begin
    tc <= (tc == 4) ? 0 : tc + 1;
    tick_ms <= (tc == 4);
  end

  // device model: dev_left -1 = busy forever, 0 = idle, >0 = cycles of busy left
  int  dev_left = 0;
  int  raise_left = -1;
  int  cfg_pre, cfg_lat, cfg_post;
  bit  cfg_present;
  bit  dev_load = 1'b0;
  assign bus_rdata = {(dev_left != 0), 7'h50};

  always @(posedge clk) begin
    if (dev_load) begin
      dev_left   <= cfg_pre;
      raise_left <= -1;
    end else if (bus_wr && bus_addr == 4'hA && bus_wdata == 8'h0E) begin
      if (cfg_present) raise_left <= cfg_lat;
    end else if (bus_wr && bus_addr == 4'hA && bus_wdata == 8'h0A) begin
      raise_left <= -1;
      if (cfg_present) dev_left <= cfg_post;
    end else begin
      if (raise_left == 0) begin
        dev_left   <= -1;
        raise_left <= -1;
      end else begin
        if (raise_left > 0) raise_left <= raise_left - 1;
        if (dev_left > 0) dev_left <= dev_left - 1;
      end
    end
  end

  // behavioural reference: phase 0 idle,1 settle,2 poll idle,3 put reset,
  // 4 seek busy,5 drop reset,6 settle,7 poll ready,8 finish
  int m_ph = 0, m_cnt = 0, m_err = 0;
  always @(posedge clk) begin : mdl
    int lim, nph, ner;
    bit hb, bs;
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_err <= 0;
    end else begin
      lim = (m_ph == 1 || m_ph == 6) ? DLY : (m_ph == 4) ? WIN : TMO;
      hb  = (m_cnt >= lim);
      bs  = bus_rdata[7];
      nph = m_ph;
      ner = m_err;
      case (m_ph)
        0: if (start) nph = 1;
        1: if (hb) nph = 2;
        2: if (!bs) nph = 3; else if (hb) begin nph = 8; ner = 1; end
        3: nph = 4;
        4: if (bs) nph = 5; else if (hb) begin nph = 8; ner = 2; end
        5: nph = 6;
        6: if (hb) nph = 7;
        7: if (!bs) begin nph = 8; ner = 0; end else if (hb) begin nph = 8; ner = 3; end
        default: nph = 0;
      endcase
      m_ph  <= nph;
      m_err <= ner;
      m_cnt <= (nph != m_ph) ? 0 : ((tick_ms && !hb) ? m_cnt + 1 : m_cnt);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run_cmp) begin
      bit e_rd, e_wr;
      int e_addr, e_wd;
      e_rd   = (m_ph == 2 || m_ph == 4 || m_ph == 7);
      e_wr   = (m_ph == 3 || m_ph == 5);
      e_addr = e_rd ? 7 : (e_wr ? 'hA : 0);
      e_wd   = (m_ph == 3) ? 'h0E : ((m_ph == 5) ? 'h0A : 0);
      chk(bus_rd == e_rd && bus_wr == e_wr, {cur_tag, " strobes (R3)"},
          {bus_rd, bus_wr}, {e_rd, e_wr});
      chk(bus_addr == e_addr[3:0] && bus_wdata == e_wd[7:0], {cur_tag, " addr/data (R4)"},
          {bus_addr, bus_wdata}, {e_addr[3:0], e_wd[7:0]});
      chk(busy == (m_ph != 0) && done == (m_ph == 8), {cur_tag, " busy/done (R9)"},
          {busy, done}, {(m_ph != 0), (m_ph == 8)});
      chk(err_code == m_err[1:0], {cur_tag, " err (R11)"}, err_code, m_err);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_seq(input int pre, input bit present, input int lat, input int post,
                         input int exp_err, input string tag, input bit repulse);
    int ndone;
    int n;
    cur_tag = tag;
    cfg_pre = pre; cfg_present = present; cfg_lat = lat; cfg_post = post;
    @(negedge clk) dev_load = 1'b1;
    @(negedge clk) dev_load = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
    ndone = 0;
    n = 0;
    while (ndone == 0 && n < 3000) begin
      @(negedge clk);
      start = (repulse && n == 8);
      if (done) ndone++;
      n++;
    end
    start = 1'b0;
    chk(ndone == 1, {tag, " done seen"}, ndone, 1);
    if (exp_err >= 0) chk(err_code == exp_err[1:0], {tag, " err at done"}, err_code, exp_err);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 1 && !busy, {tag, " R9 single completion"}, ndone, 1);
    chk(err_code == exp_err[1:0] || exp_err < 0, {tag, " R11 err held"}, err_code, exp_err);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && err_code == 0 && !bus_rd && !bus_wr && bus_addr == 0 && bus_wdata == 0,
        "R1 in reset", {busy, done, bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && err_code == 0 && !bus_rd && !bus_wr, "R1 after reset",
        {busy, done, bus_rd, bus_wr}, 0);
    run_cmp = 1'b1;
    // R2 R3 R4 R5: device idle at once, reacts to reset, recovers
    run_seq(0, 1'b1, 1, 20, 0, "R5 normal", 1'b0);
    // R3: busy for a while before reset
    run_seq(15, 1'b1, 0, 3, 0, "R3 pre-busy", 1'b0);
    // R6: never idle before reset
    run_seq(-1, 1'b1, 1, 3, 1, "R6 busy pre", 1'b0);
    // R7: no device answers
    run_seq(0, 1'b0, 1, 3, 2, "R7 absent", 1'b0);
    // R7: reaction too late for the window
    run_seq(0, 1'b1, 60, 3, 2, "R7 late", 1'b0);
    // R8: never ready after release
    run_seq(0, 1'b1, 1, -1, 3, "R8 busy post", 1'b0);
    // R9: start pulse during a running sequence is ignored
    run_seq(0, 1'b1, 2, 10, 0, "R9 restart ignored", 1'b1);
    // R10: sweep busy length across the time-out boundary
    for (int len = 24; len <= 48; len++) begin
      run_seq(len, 1'b1, 1, 2, -1, "R10 sweep", 1'b0);
    end
    run_cmp = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule